// File: doc/BRIEF.md
# Floating-Point Unit State Initializer

This block holds the architectural control state of a stack-based floating-point unit. That state is the control word, the status word, the tag word, the last instruction pointer, the last data pointer and the last opcode. It watches a stream of instruction bytes, one byte per valid cycle. It reacts to two sequences:

- `DB E3` is the non-waiting initialize.
- A leading `9B` byte is a separate wait step. The waiting initialize is `9B DB E3`, which the block runs as a wait step followed by a non-waiting initialize.

Each executing step is checked for faults:

- A LOCK prefix gives an invalid-opcode fault.
- A set emulation bit or task-switched bit gives a device-not-available fault.
- A pending unmasked exception gives a math fault, on a wait step only.

When a step faults, the block reports the single fault with the highest priority and leaves its state unchanged. When an initialize step runs without a fault, the block loads the default state and pulses a done output.

The rest of the unit updates these registers through a simple write port. Read ports show every register at all times. The register stack contents and the arithmetic belong elsewhere.

Top module: `fpinit_core`

## Requirements
- R1: Synchronous reset (`rst` high at a rising edge) loads control word 16'h037F, status word 0, tag word all ones, and zero into the instruction pointer, data pointer and opcode registers. The decoder returns to idle and all fault and done outputs are 0.
- R2: An accepted `8'hDB` byte followed by an accepted `8'hE3` byte starts an initialize step. Cycles with `in_valid` low may sit between the two bytes. If the step has no fault, the default values of R1 appear on the read ports on the edge that accepts `E3`, and `init_done` is high for exactly the following cycle.
- R3: The non-waiting initialize ignores `fp_pending`.
- R4: An accepted `8'h9B` byte in idle is a wait step. `fp_pending` is sampled in that same cycle. If it is 1 and no higher fault applies, `fault_mf` pulses for one cycle and no state changes.
- R5: A wait step with no fault changes no state and produces no done, fault or pending decode.
- R6: If `cr_em` or `cr_ts` is 1 on an executing step and the LOCK flag is clear, `fault_nm` pulses and the state registers keep their values.
- R7: If `in_lock` is 1 on an executing step, `fault_ud` pulses and no initialization happens.
- R8: Fault priority is invalid opcode, then device-not-available, then math. At most one of `fault_ud`, `fault_nm`, `fault_mf` and `init_done` is high in any cycle.
- R9: After `DB`, any accepted byte other than `E3` returns the decoder to idle with no effect. That byte is not decoded again, so `DB DB E3` does not initialize and `DB 9B` performs no wait step.
- R10: With `wr_en` high, `wr_sel` selects the target register: 0 control, 1 status, 2 tag, 3 instruction pointer, 4 data pointer, 5 opcode. The low bits of `wr_data` are written on the edge. An initialize step on the same edge wins over the write.
- R11: The tag word is 2 bits per stack register and reads `2'b11` for every register after reset or initialize.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction byte valid |
| in_byte | input | 8 | Instruction byte |
| in_lock | input | 1 | LOCK prefix present on this byte's instruction |
| cr_em | input | 1 | Emulation control bit |
| cr_ts | input | 1 | Task-switched control bit |
| fp_pending | input | 1 | Unmasked exception pending |
| wr_en | input | 1 | State write enable |
| wr_sel | input | 3 | State write target |
| wr_data | input | WR_W | State write data |
| fault_ud | output | 1 | Invalid-opcode fault pulse |
| fault_nm | output | 1 | Device-not-available fault pulse |
| fault_mf | output | 1 | Math fault pulse |
| init_done | output | 1 | Initialization complete pulse |
| cw | output | 16 | Control word |
| sw | output | 16 | Status word |
| tw | output | 2*NREGS | Tag word |
| ip | output | IP_W | Last instruction pointer |
| dp | output | DP_W | Last data pointer |
| opc | output | OP_W | Last opcode |

## Verification
The bench builds the block with its defaults: eight stack registers, 32-bit pointers and an 11-bit opcode. With these values the tag word is 16 bits, so the all-empty pattern is the full 16'hFFFF. Pointer writes of arbitrary 32-bit values make any missed clear visible. The bench drives each byte of a sequence as its own input cycle, so the fault flags can be set on the wait byte alone or on the final byte alone. This exercises the ordering of the fault checks and the rule that a pending exception only matters on the wait step.

// File: rtl/fpinit_pkg.sv
package fpinit_pkg;

  localparam logic [7:0]  BYTE_WAIT  = 8'h9B;
  localparam logic [7:0]  BYTE_ESC   = 8'hDB;
  localparam logic [7:0]  BYTE_INIT  = 8'hE3;
  localparam logic [15:0] CW_DEFAULT = 16'h037F;

  typedef enum logic [0:0] {DS_IDLE = 1'b0, DS_PFX = 1'b1} dec_st_e;

  typedef enum logic [2:0] {
    WS_CW = 3'd0, WS_SW = 3'd1, WS_TW = 3'd2,
    WS_IP = 3'd3, WS_DP = 3'd4, WS_OP = 3'd5
  } wr_sel_e;

  typedef struct packed {
    logic ud;
    logic nm;
    logic mf;
  } fault_t;

  // Empty-tag pattern: two set bits per stack register.
  function automatic logic [63:0] tag_fill(int unsigned nregs);
    logic [63:0] v;
    v = '0;
    for (int i = 0; i < 32; i++) begin
      if (i < int'(nregs)) v[2*i +: 2] = 2'b11;
    end
    return v;
  endfunction

  // Highest-priority fault for one executing step.
  function automatic fault_t pick_fault(logic lock, logic em, logic ts,
                                        logic pend, logic is_wait);
    fault_t f;
    f = '0;
    if (lock)                 f.ud = 1'b1;
    else if (em || ts)        f.nm = 1'b1;
    else if (is_wait && pend) f.mf = 1'b1;
    return f;
  endfunction

endpackage

// File: rtl/fpinit_decode.sv
module fpinit_decode
  import fpinit_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       wait_step,
  output logic       init_step
);

  dec_st_e st_q, st_d;

  always_comb begin
    st_d      = st_q;
    wait_step = 1'b0;
    init_step = 1'b0;
    if (!rst && in_valid) begin
      unique case (st_q)
        DS_IDLE: begin
          if (in_byte == BYTE_WAIT)     wait_step = 1'b1;
          else if (in_byte == BYTE_ESC) st_d = DS_PFX;
        end
        DS_PFX: begin
          st_d = DS_IDLE;
          if (in_byte == BYTE_INIT) init_step = 1'b1;
        end
        default: st_d = DS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= DS_IDLE;
    else     st_q <= st_d;
  end

  // R9
  bad_second_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == DS_PFX && in_valid && in_byte != BYTE_INIT) |=> (st_q == DS_IDLE));

  // R2
  init_after_escape_chk: assert property (@(posedge clk) disable iff (rst)
    init_step |-> (st_q == DS_PFX));

endmodule

// File: rtl/fpinit_fault.sv
module fpinit_fault
  import fpinit_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wait_step,
  input  logic init_step,
  input  logic in_lock,
  input  logic cr_em,
  input  logic cr_ts,
  input  logic fp_pending,
  output logic fault_any,
  output logic init_go,
  output logic fault_ud,
  output logic fault_nm,
  output logic fault_mf,
  output logic init_done
);

  fault_t f_now;
  logic   step_any;

  assign step_any  = wait_step | init_step;
  assign f_now     = step_any ? pick_fault(in_lock, cr_em, cr_ts, fp_pending, wait_step) : '0;
  assign fault_any = |f_now;
  assign init_go   = init_step & ~fault_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_ud  <= 1'b0;
      fault_nm  <= 1'b0;
      fault_mf  <= 1'b0;
      init_done <= 1'b0;
    end else begin
      fault_ud  <= f_now.ud;
      fault_nm  <= f_now.nm;
      fault_mf  <= f_now.mf;
      init_done <= init_go;
    end
  end

  // R8
  single_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fault_ud, fault_nm, fault_mf, init_done}));

  // R7
  lock_faults_chk: assert property (@(posedge clk) disable iff (rst)
    (step_any && in_lock) |=> fault_ud);

  // R4
  math_only_on_wait_chk: assert property (@(posedge clk) disable iff (rst)
    fault_mf |-> $past(wait_step));

  // R3
  noinit_ignores_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (init_step && !in_lock && !cr_em && !cr_ts) |=> init_done);

endmodule

// File: rtl/fpinit_state.sv
module fpinit_state
  import fpinit_pkg::*;
#(
  parameter int NREGS = 8,
  parameter int IP_W  = 32,
  parameter int DP_W  = 32,
  parameter int OP_W  = 11,
  parameter int WR_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_go,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [WR_W-1:0]   wr_data,
  output logic [15:0]       cw,
  output logic [15:0]       sw,
  output logic [2*NREGS-1:0] tw,
  output logic [IP_W-1:0]   ip,
  output logic [DP_W-1:0]   dp,
  output logic [OP_W-1:0]   opc
);

  localparam int TW_W = 2 * NREGS;
  localparam logic [TW_W-1:0] TW_DEFAULT = TW_W'(tag_fill(NREGS));

  logic load_def;
  assign load_def = rst | init_go;

  always_ff @(posedge clk) begin
    if (load_def) begin
      cw  <= CW_DEFAULT;
      sw  <= '0;
      tw  <= TW_DEFAULT;
      ip  <= '0;
      dp  <= '0;
      opc <= '0;
    end else if (wr_en) begin
      unique case (wr_sel_e'(wr_sel))
        WS_CW: cw  <= wr_data[15:0];
        WS_SW: sw  <= wr_data[15:0];
        WS_TW: tw  <= wr_data[TW_W-1:0];
        WS_IP: ip  <= wr_data[IP_W-1:0];
        WS_DP: dp  <= wr_data[DP_W-1:0];
        WS_OP: opc <= wr_data[OP_W-1:0];
        default: ;
      endcase
    end
  end

  // R2 R11
  defaults_after_init_chk: assert property (@(posedge clk) disable iff (rst)
    init_go |=> (cw == CW_DEFAULT && sw == '0 && tw == {TW_W{1'b1}} &&
                 ip == '0 && dp == '0 && opc == '0));

endmodule

// File: rtl/fpinit_core.sv
module fpinit_core
  import fpinit_pkg::*;
#(
  parameter int NREGS = 8,
  parameter int IP_W  = 32,
  parameter int DP_W  = 32,
  parameter int OP_W  = 11,
  localparam int WR_W = (IP_W > DP_W) ? ((IP_W > 16) ? IP_W : 16)
                                      : ((DP_W > 16) ? DP_W : 16)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [7:0]         in_byte,
  input  logic               in_lock,
  input  logic               cr_em,
  input  logic               cr_ts,
  input  logic               fp_pending,
  input  logic               wr_en,
  input  logic [2:0]         wr_sel,
  input  logic [WR_W-1:0]    wr_data,
  output logic               fault_ud,
  output logic               fault_nm,
  output logic               fault_mf,
  output logic               init_done,
  output logic [15:0]        cw,
  output logic [15:0]        sw,
  output logic [2*NREGS-1:0] tw,
  output logic [IP_W-1:0]    ip,
  output logic [DP_W-1:0]    dp,
  output logic [OP_W-1:0]    opc
);

  logic wait_step, init_step, fault_any, init_go;

  fpinit_decode u_decode (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .wait_step (wait_step),
    .init_step (init_step)
  );

  fpinit_fault u_fault (
    .clk        (clk),
    .rst        (rst),
    .wait_step  (wait_step),
    .init_step  (init_step),
    .in_lock    (in_lock),
    .cr_em      (cr_em),
    .cr_ts      (cr_ts),
    .fp_pending (fp_pending),
    .fault_any  (fault_any),
    .init_go    (init_go),
    .fault_ud   (fault_ud),
    .fault_nm   (fault_nm),
    .fault_mf   (fault_mf),
    .init_done  (init_done)
  );

  fpinit_state #(
    .NREGS (NREGS), .IP_W (IP_W), .DP_W (DP_W), .OP_W (OP_W), .WR_W (WR_W)
  ) u_state (
    .clk     (clk),
    .rst     (rst),
    .init_go (init_go),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .cw      (cw),
    .sw      (sw),
    .tw      (tw),
    .ip      (ip),
    .dp      (dp),
    .opc     (opc)
  );

  // R6
  hold_on_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_any && !wr_en) |=> ($stable(cw) && $stable(sw) && $stable(tw) &&
                               $stable(ip) && $stable(dp) && $stable(opc)));

  // R5
  wait_no_done_chk: assert property (@(posedge clk) disable iff (rst)
    wait_step |=> !init_done);

endmodule

// File: tb/fpinit_core_tb.sv
module fpinit_core_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        in_lock = 1'b0, cr_em = 1'b0, cr_ts = 1'b0, fp_pending = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [31:0] wr_data = 32'd0;
  logic        fault_ud, fault_nm, fault_mf, init_done;
  logic [15:0] cw, sw, tw;
  logic [31:0] ip, dp;
  logic [10:0] opc;

  fpinit_core u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_lock(in_lock), .cr_em(cr_em), .cr_ts(cr_ts), .fp_pending(fp_pending),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .fault_ud(fault_ud), .fault_nm(fault_nm), .fault_mf(fault_mf),
    .init_done(init_done), .cw(cw), .sw(sw), .tw(tw), .ip(ip), .dp(dp), .opc(opc)
  );

  always #5 clk = ~clk;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    finished = 0;
  bit    started = 0;
  string cur_req = "R1";

  // Behavioural reference: the full expected register set and outputs.
  int unsigned m_reg[6];
  bit          m_after_db;
  bit [3:0]    m_out;  // {ud, nm, mf, done}

  function automatic void m_defaults();
    m_reg[0] = 32'h037F; m_reg[1] = 0; m_reg[2] = 32'hFFFF;
    m_reg[3] = 0; m_reg[4] = 0; m_reg[5] = 0;
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_defaults();
      m_after_db = 0;
      m_out = 4'b0000;
    end else begin
      bit is_wait, is_init, okay;
      bit [3:0] o;
      is_wait = 0; is_init = 0; o = 4'b0000;
      if (in_valid) begin
        if (m_after_db) begin
          is_init = (in_byte == 8'hE3);
          m_after_db = 0;
        end else if (in_byte == 8'h9B) is_wait = 1;
        else if (in_byte == 8'hDB) m_after_db = 1;
      end
      if (is_wait || is_init) begin
        if (in_lock)                          o = 4'b1000;
        else if (cr_em || cr_ts)              o = 4'b0100;
        else if (is_wait && fp_pending)       o = 4'b0010;
        else if (is_init)                     o = 4'b0001;
      end
      m_out = o;
      okay = o[0];
      if (okay) m_defaults();
      else if (wr_en && wr_sel <= 3'd5) begin
        case (wr_sel)
          3'd0, 3'd1, 3'd2: m_reg[wr_sel] = wr_data & 32'hFFFF;
          3'd5:             m_reg[5] = wr_data & 32'h7FF;
          default:          m_reg[wr_sel] = wr_data;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      n_tests++;
      if ({fault_ud, fault_nm, fault_mf, init_done} !== m_out) begin
        n_fail++;
        $display("FAIL %s outputs ud/nm/mf/done actual=%b expected=%b", cur_req,
                 {fault_ud, fault_nm, fault_mf, init_done}, m_out);
      end
      n_tests++;
      if (cw !== m_reg[0][15:0] || sw !== m_reg[1][15:0] || tw !== m_reg[2][15:0] ||
          ip !== m_reg[3] || dp !== m_reg[4] || opc !== m_reg[5][10:0]) begin
        n_fail++;
        $display("FAIL %s state actual=%h %h %h %h %h %h expected=%h %h %h %h %h %h",
                 cur_req, cw, sw, tw, ip, dp, opc, m_reg[0][15:0], m_reg[1][15:0],
                 m_reg[2][15:0], m_reg[3], m_reg[4], m_reg[5][10:0]);
      end
    end
  end

  task automatic idle_cycle();
    in_valid = 0; wr_en = 0;
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input bit lk, input bit em,
                      input bit ts, input bit pd);
    in_valid = 1; in_byte = b; in_lock = lk; cr_em = em; cr_ts = ts; fp_pending = pd;
    wr_en = 0;
    @(negedge clk);
    in_valid = 0; in_lock = 0; cr_em = 0; cr_ts = 0; fp_pending = 0;
  endtask

  task automatic write_reg(input logic [2:0] s, input logic [31:0] d);
    in_valid = 0; wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic dirty();
    write_reg(3'd0, 32'h0000_1A2B);
    write_reg(3'd1, 32'h0000_BEEF);
    write_reg(3'd2, 32'h0000_0F0F);
    write_reg(3'd3, 32'hDEAD_BEEF);
    write_reg(3'd4, 32'h1234_5678);
    write_reg(3'd5, 32'h0000_05A5);
  endtask

  task automatic direct_check(input string req, input bit ok, input logic [31:0] act,
                              input logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cur_req = "R1";
    direct_check("R1", cw == 16'h037F, {16'h0, cw}, 32'h037F);
    direct_check("R11", tw == 16'hFFFF, {16'h0, tw}, 32'hFFFF);

    cur_req = "R10"; dirty();
    direct_check("R10", ip == 32'hDEAD_BEEF, ip, 32'hDEAD_BEEF);

    cur_req = "R2"; send(8'hDB, 0, 0, 0, 0); send(8'hE3, 0, 0, 0, 0); idle_cycle();
    cur_req = "R2"; dirty(); send(8'hDB, 0, 0, 0, 0); idle_cycle(); idle_cycle();
    send(8'hE3, 0, 0, 0, 0); idle_cycle();
    cur_req = "R3"; dirty(); send(8'hDB, 0, 0, 0, 1); send(8'hE3, 0, 0, 0, 1);
    cur_req = "R4"; dirty(); send(8'h9B, 0, 0, 0, 1); idle_cycle();
    cur_req = "R5"; send(8'h9B, 0, 0, 0, 0); idle_cycle();
    cur_req = "R5"; send(8'h9B, 0, 0, 0, 0); send(8'hDB, 0, 0, 0, 0);
    send(8'hE3, 0, 0, 0, 0);
    cur_req = "R6"; dirty(); send(8'hDB, 0, 0, 0, 0); send(8'hE3, 0, 1, 0, 0);
    send(8'hDB, 0, 0, 0, 0); send(8'hE3, 0, 0, 1, 0);
    send(8'h9B, 0, 0, 1, 0);
    cur_req = "R7"; send(8'hDB, 0, 0, 0, 0); send(8'hE3, 1, 0, 0, 0);
    send(8'h9B, 1, 0, 0, 0);
    cur_req = "R8"; send(8'h9B, 1, 1, 1, 1); send(8'h9B, 0, 1, 0, 1);
    send(8'hDB, 0, 0, 0, 1); send(8'hE3, 1, 1, 1, 1);
    cur_req = "R9"; send(8'hDB, 0, 0, 0, 0); send(8'h00, 0, 0, 0, 0);
    send(8'hE3, 0, 0, 0, 0);
    send(8'hDB, 0, 0, 0, 0); send(8'hDB, 0, 0, 0, 0); send(8'hE3, 0, 0, 0, 0);
    send(8'hDB, 0, 0, 0, 0); send(8'h9B, 0, 0, 0, 1); idle_cycle();
    direct_check("R9", cw == 16'h1A2B, {16'h0, cw}, 32'h1A2B);
    cur_req = "R10"; // init wins over a same-edge write
    send(8'hDB, 0, 0, 0, 0);
    in_valid = 1; in_byte = 8'hE3; wr_en = 1; wr_sel = 3'd3; wr_data = 32'h5555_AAAA;
    @(negedge clk);
    in_valid = 0; wr_en = 0;
    direct_check("R10", ip == 32'h0, ip, 32'h0);

    cur_req = "R8";
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] pick[4];
      pick[0] = 8'h9B; pick[1] = 8'hDB; pick[2] = 8'hE3; pick[3] = 8'($urandom);
      in_valid   = ($urandom % 4) != 0;
      in_byte    = pick[$urandom % 4];
      in_lock    = ($urandom % 8) == 0;
      cr_em      = ($urandom % 8) == 0;
      cr_ts      = ($urandom % 8) == 0;
      fp_pending = ($urandom % 2) == 0;
      wr_en      = ($urandom % 4) == 0;
      wr_sel     = 3'($urandom % 8);
      wr_data    = $urandom;
      @(negedge clk);
    end
    in_valid = 0; wr_en = 0;
    idle_cycle();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule